// File: doc/BRIEF.md
# CAN Bit Timing and Resynchronization Unit

This block divides each CAN bit into time quanta and decides where the receive level is sampled. A time-quantum enable pulse from an external prescaler drives it. Each bit holds a one-quantum synchronization slot, a propagation slot, a first phase slot and a second phase slot. The lengths of the propagation and phase slots, and the jump-width limit, come from configuration inputs. The receive line first passes through a two-stage synchronizer. At each quantum the unit compares the line with its value at the previous quantum, so that it can find falling edges, that is, recessive-to-dominant changes.

While the frame logic reports the bus as idle, a falling edge causes a hard synchronization: the quantum that holds the edge becomes the synchronization slot, and no jump-width limit applies. Inside a frame, a falling edge causes a soft resynchronization. An edge after the synchronization slot but before the sample point stretches the first phase slot. An edge in the second phase slot cuts that slot short. The amount of stretching or cutting is capped by the jump width. Internally a bit runs from one sample point to the next. At most one soft resynchronization happens in that span, and none happens when the last sampled level was dominant.

The outputs are a sample strobe that carries the sampled level and a bit-boundary strobe. The sample strobe is a valid pulse with no ready signal, because bus timing cannot be stalled and a consumer must take every strobe. The other pins are plain level signals.

Top module: `canbit_resync`

## Requirements
- R1: After reset, sample_stb and bit_stb are low and sample_bit is 1 (recessive).
- R2: The state advances only on clocks where tq_en is high. Each strobe is one clock wide and appears in the clock that follows that tq_en clock.
- R3: Without resynchronization, a bit lasts 1+P+A+B quanta, where P, A and B are the prop_len, ph1_len and ph2_len values. sample_stb marks the end of quantum 1+P+A and bit_stb marks the end of the last second-phase quantum. sample_bit takes the synchronized rx level at the sample quantum (1 recessive, 0 dominant) and holds it until the next sample_stb.
- R4: A falling edge while bus_idle is 1 raises bit_stb for that quantum. The next sample comes P+A quanta later, whatever the current position in the bit.
- R5: For a falling edge in the k-th quantum after the synchronization slot (k counted from 1) before the sample point, the sample is delayed by min(k, sjw_len) quanta.
- R6: For a falling edge in second-phase quantum j (j counted from 0), the error is B−j. If the error is at most sjw_len, the bit ends in that quantum with bit_stb, the synchronization slot is skipped and the sample follows P+A quanta later.
- R7: If that error exceeds sjw_len, the second phase is shortened by sjw_len and a normal synchronization slot follows.
- R8: Any lengthening or shortening applies only to the current bit. The next bit has nominal lengths.
- R9: At most one soft resynchronization takes place between two sample points.
- R10: No soft resynchronization takes place while the last sampled level is dominant.
- R11: Dominant-to-recessive edges never move the timing.
- R12: Consider a dominant spike that starts after the propagation slot and lasts P+A quanta. With sjw_len at least P+1 it is skipped and recessive is sampled. With a smaller sjw_len it is sampled as dominant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tq_en | input | 1 | One-clock pulse per time quantum |
| rx_in | input | 1 | Asynchronous receive line, 1 recessive |
| bus_idle | input | 1 | High when hard synchronization is allowed |
| prop_len | input | SEG_W | Propagation slot length, 1 to 8 |
| ph1_len | input | SEG_W | First phase slot length, 1 to 8 |
| ph2_len | input | SEG_W | Second phase slot length, 2 to 8 |
| sjw_len | input | SJW_W | Jump width, 1 to 4, not above either phase length |
| sample_stb | output | 1 | Sample point strobe (valid) |
| sample_bit | output | 1 | Level taken at the last sample point |
| bit_stb | output | 1 | Bit boundary strobe |

## Verification
The bench places falling edges at chosen quanta. A late edge inside the jump width must delay the sample by the full error. A design that ignored the cap, or lost the extension, would sample one or two quanta off. Early edges are placed so that one is fully compensated, which must skip the synchronization slot, and one is not, which must keep it; a design that confused the two would move the next sample by one quantum. The bench also checks that an adjustment ends after one bit, that a second edge in the same bit and an edge after a dominant sample leave the timing alone, and that a dominant spike is skipped or sampled depending on whether the jump width reaches its phase error.

// File: rtl/canbit_pkg.sv
package canbit_pkg;
  typedef enum logic [1:0] {
    SEG_SYNC = 2'd0,
    SEG_TS1  = 2'd1,
    SEG_PH2  = 2'd2
  } seg_e;
endpackage

// File: rtl/canbit_sync2.sv
module canbit_sync2 #(
  parameter int  STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr <= {STAGES{RST_VAL}};
    else        sr <= {sr[STAGES-2:0], d};
  end

  assign q = sr[STAGES-1];
endmodule

// File: rtl/canbit_edge.sv
module canbit_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic tq_en,
  input  logic rx_s,
  output logic fall
);
  logic rx_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rx_prev <= 1'b1;
    else if (tq_en) rx_prev <= rx_s;
  end

  // recessive at the previous quantum, dominant now
  assign fall = tq_en & rx_prev & ~rx_s;
endmodule

// File: rtl/canbit_seq.sv
module canbit_seq
  import canbit_pkg::*;
#(
  parameter int SEG_W = 4,
  parameter int SJW_W = 3,
  parameter int CNT_W = SEG_W + 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tq_en,
  input  logic             rx_s,
  input  logic             fall,
  input  logic             bus_idle,
  input  logic [SEG_W-1:0] prop_len,
  input  logic [SEG_W-1:0] ph1_len,
  input  logic [SEG_W-1:0] ph2_len,
  input  logic [SJW_W-1:0] sjw_len,
  output logic             sample_stb,
  output logic             sample_bit,
  output logic             bit_stb,
  output logic [CNT_W-1:0] ext_cur
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  seg_e             seg_q;
  logic [CNT_W-1:0] cnt_q, ext_q, shr_q;
  logic             done_q, samp_q, s_stb_q, b_stb_q;

  logic [CNT_W-1:0] sjw_c, ph2_c, ts1_base, late_err, early_err;
  logic [CNT_W-1:0] ext_n, shr_n, ts1_lim, ph2_lim;
  logic             resync_ok, hard, late, early, early_full, ts1_end, ph2_end;

  always_comb begin
    sjw_c      = CNT_W'(sjw_len);
    ph2_c      = CNT_W'(ph2_len);
    ts1_base   = CNT_W'(prop_len) + CNT_W'(ph1_len);
    late_err   = cnt_q + ONE;
    early_err  = ph2_c - cnt_q;
    hard       = fall & bus_idle;
    resync_ok  = fall & ~bus_idle & ~done_q & samp_q;
    late       = resync_ok && (seg_q == SEG_TS1);
    early      = resync_ok && (seg_q == SEG_PH2);
    early_full = early && (early_err <= sjw_c);
    ext_n      = late ? ((late_err < sjw_c) ? late_err : sjw_c) : ext_q;
    shr_n      = (early && !early_full) ? sjw_c : shr_q;
    ts1_lim    = ts1_base + ext_n;
    ph2_lim    = ph2_c - shr_n;
    ts1_end    = (cnt_q == ts1_lim - ONE);
    ph2_end    = (cnt_q == ph2_lim - ONE);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seg_q   <= SEG_SYNC;
      cnt_q   <= '0;
      ext_q   <= '0;
      shr_q   <= '0;
      done_q  <= 1'b0;
      samp_q  <= 1'b1;
      s_stb_q <= 1'b0;
      b_stb_q <= 1'b0;
    end else begin
      s_stb_q <= 1'b0;
      b_stb_q <= 1'b0;
      if (tq_en) begin
        if (hard) begin
          seg_q   <= SEG_TS1;
          cnt_q   <= '0;
          ext_q   <= '0;
          shr_q   <= '0;
          done_q  <= 1'b1;
          b_stb_q <= 1'b1;
        end else begin
          unique case (seg_q)
            SEG_SYNC: begin
              seg_q <= SEG_TS1;
              cnt_q <= '0;
            end
            SEG_TS1: begin
              if (ts1_end) begin
                seg_q   <= SEG_PH2;
                cnt_q   <= '0;
                ext_q   <= '0;
                done_q  <= 1'b0;
                samp_q  <= rx_s;
                s_stb_q <= 1'b1;
              end else begin
                cnt_q  <= cnt_q + ONE;
                ext_q  <= ext_n;
                done_q <= done_q | late;
              end
            end
            SEG_PH2: begin
              if (early_full) begin
                seg_q   <= SEG_TS1;
                cnt_q   <= '0;
                shr_q   <= '0;
                done_q  <= 1'b1;
                b_stb_q <= 1'b1;
              end else if (ph2_end) begin
                seg_q   <= SEG_SYNC;
                cnt_q   <= '0;
                shr_q   <= '0;
                b_stb_q <= 1'b1;
              end else begin
                cnt_q  <= cnt_q + ONE;
                shr_q  <= shr_n;
                done_q <= done_q | early;
              end
            end
            default: begin
              seg_q <= SEG_SYNC;
              cnt_q <= '0;
            end
          endcase
        end
      end
    end
  end

  assign sample_stb = s_stb_q;
  assign sample_bit = samp_q;
  assign bit_stb    = b_stb_q;
  assign ext_cur    = ext_q;
endmodule

// File: rtl/canbit_resync.sv
module canbit_resync #(
  parameter int SEG_W       = 4,
  parameter int SJW_W       = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tq_en,
  input  logic             rx_in,
  input  logic             bus_idle,
  input  logic [SEG_W-1:0] prop_len,
  input  logic [SEG_W-1:0] ph1_len,
  input  logic [SEG_W-1:0] ph2_len,
  input  logic [SJW_W-1:0] sjw_len,
  output logic             sample_stb,
  output logic             sample_bit,
  output logic             bit_stb
);
  localparam int CNT_W = SEG_W + 2;

  logic             rx_s, fall;
  logic [CNT_W-1:0] ext_cur;

  canbit_sync2 #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(rx_in), .q(rx_s)
  );

  canbit_edge u_edge (
    .clk(clk), .rst_n(rst_n), .tq_en(tq_en), .rx_s(rx_s), .fall(fall)
  );

  canbit_seq #(.SEG_W(SEG_W), .SJW_W(SJW_W), .CNT_W(CNT_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .tq_en(tq_en), .rx_s(rx_s), .fall(fall),
    .bus_idle(bus_idle), .prop_len(prop_len), .ph1_len(ph1_len),
    .ph2_len(ph2_len), .sjw_len(sjw_len), .sample_stb(sample_stb),
    .sample_bit(sample_bit), .bit_stb(bit_stb), .ext_cur(ext_cur)
  );
endmodule

// File: rtl/canbit_resync_chk.sv
module canbit_resync_chk #(
  parameter int SJW_W = 3,
  parameter int CNT_W = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tq_en,
  input logic             sample_stb,
  input logic             sample_bit,
  input logic             bit_stb,
  input logic [SJW_W-1:0] sjw_len,
  input logic [CNT_W-1:0] ext_cur
);
  logic seen_bit, had_sample;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_bit   <= 1'b0;
      had_sample <= 1'b0;
    end else begin
      if (sample_stb) begin
        had_sample <= 1'b1;
        seen_bit   <= 1'b0;
      end else if (bit_stb) begin
        seen_bit <= 1'b1;
      end
    end
  end

  // R2
  strobe_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_stb || bit_stb) |-> $past(tq_en));

  // R3
  strobe_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(sample_stb && bit_stb));

  // R3
  level_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sample_stb |-> $stable(sample_bit));

  // R3
  boundary_between_samples_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_stb && had_sample) |-> seen_bit);

  // R5
  ext_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ext_cur <= CNT_W'(sjw_len));
endmodule

bind canbit_resync canbit_resync_chk #(.SJW_W(SJW_W), .CNT_W(SEG_W + 2)) chk_i (
  .clk(clk), .rst_n(rst_n), .tq_en(tq_en), .sample_stb(sample_stb),
  .sample_bit(sample_bit), .bit_stb(bit_stb), .sjw_len(sjw_len),
  .ext_cur(ext_cur)
);

// File: tb/canbit_resync_tb_top.sv
`timescale 1ns/1ps
module canbit_resync_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tq_en = 1'b0;
  logic       rx_in = 1'b1;
  logic       bus_idle = 1'b0;
  logic [3:0] prop_len, ph1_len, ph2_len;
  logic [2:0] sjw_len;
  logic       sample_stb, sample_bit, bit_stb;
  logic       got_s, got_b, got_v;
  int         checks = 0;
  int         errors = 0;
  bit         finished = 1'b0;

  always #2 clk = ~clk;

  canbit_resync dut_i (
    .clk(clk), .rst_n(rst_n), .tq_en(tq_en), .rx_in(rx_in),
    .bus_idle(bus_idle), .prop_len(prop_len), .ph1_len(ph1_len),
    .ph2_len(ph2_len), .sjw_len(sjw_len), .sample_stb(sample_stb),
    .sample_bit(sample_bit), .bit_stb(bit_stb)
  );

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic do_tick(logic lvl);
    rx_in = lvl;
    repeat (3) @(negedge clk);
    tq_en = 1'b1;
    @(negedge clk);
    tq_en = 1'b0;
    got_s = sample_stb;
    got_b = bit_stb;
    got_v = sample_bit;
  endtask

  task automatic set_cfg(int p, int a, int b, int s);
    prop_len = 4'(p);
    ph1_len  = 4'(a);
    ph2_len  = 4'(b);
    sjw_len  = 3'(s);
  endtask

  task automatic hsync(string req);
    do_tick(1'b1);
    bus_idle = 1'b1;
    do_tick(1'b0);
    bus_idle = 1'b0;
    chk({req, " R4"}, "bit_stb at hard sync", got_b, 1);
    chk({req, " R4"}, "sample_stb at hard sync", got_s, 0);
  endtask

  // rel tick 0 is the hard sync; dominant in [a1,b1] and [a2,b2]
  task automatic scen(string req, int n, int a1, int b1, int a2, int b2,
                      int s1, int s2, int s3, logic v2, int t1, int t2);
    hsync(req);
    for (int k = 1; k <= n; k++) begin
      logic lv;
      lv = !((k >= a1 && k <= b1) || (k >= a2 && k <= b2));
      do_tick(lv);
      chk(req, $sformatf("sample_stb tick %0d", k), got_s,
          ((k == s1) || (k == s2) || (k == s3)) ? 1 : 0);
      chk(req, $sformatf("bit_stb tick %0d", k), got_b,
          ((k == t1) || (k == t2)) ? 1 : 0);
      if (k == s2) chk(req, "sample_bit", got_v, v2);
    end
  endtask

  task automatic t_reset;
    chk("R1", "sample_bit", sample_bit, 1);
    chk("R1", "sample_stb", sample_stb, 0);
    chk("R1", "bit_stb", bit_stb, 0);
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (i % 10 == 9) chk("R2", "strobes without tq_en", sample_stb | bit_stb, 0);
    end
  endtask

  task automatic t_nominal;
    set_cfg(2, 3, 3, 2);
    scen("R3 R11", 17, 1, 3, 0, 0, 5, 14, 0, 1'b1, 8, 17);
  endtask

  task automatic t_late_full;
    set_cfg(2, 3, 3, 2);
    scen("R5 R8", 25, 11, 40, 0, 0, 5, 16, 25, 1'b0, 8, 19);
  endtask

  task automatic t_late_cap;
    set_cfg(2, 3, 3, 1);
    scen("R5 cap", 24, 11, 40, 0, 0, 5, 15, 24, 1'b0, 8, 18);
  endtask

  task automatic t_early_full;
    set_cfg(2, 3, 3, 2);
    scen("R6", 21, 7, 40, 0, 0, 5, 12, 21, 1'b0, 7, 15);
  endtask

  task automatic t_early_cap;
    set_cfg(2, 3, 3, 1);
    scen("R7", 22, 7, 40, 0, 0, 5, 13, 22, 1'b0, 7, 16);
  endtask

  task automatic t_one_per_bit;
    set_cfg(2, 3, 3, 2);
    scen("R9", 21, 7, 7, 9, 40, 5, 12, 21, 1'b0, 7, 15);
  endtask

  task automatic t_dom_block;
    set_cfg(2, 3, 3, 2);
    scen("R10", 17, 1, 5, 7, 40, 5, 14, 0, 1'b0, 8, 17);
  endtask

  task automatic t_spike_reject;
    set_cfg(2, 4, 4, 3);
    scen("R12 reject", 24, 14, 19, 0, 0, 6, 20, 0, 1'b1, 10, 24);
  endtask

  task automatic t_spike_pass;
    set_cfg(2, 4, 4, 2);
    scen("R12 pass", 23, 14, 19, 0, 0, 6, 19, 0, 1'b0, 10, 23);
  endtask

  initial begin
    set_cfg(2, 3, 3, 2);
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_nominal();
    t_late_full();
    t_late_cap();
    t_early_full();
    t_early_cap();
    t_one_per_bit();
    t_dom_block();
    t_spike_reject();
    t_spike_pass();
    if (!finished) begin
      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule